// File: doc/BRIEF.md
# Vector Register Read-Port Router

This block sits between vector instruction decode and the vector register file. Each cycle it takes the three source register fields of a vector instruction, a 3-bit routing mode chosen by decode from the opcode and condition state, and the index of the extra vector register. From these it forms the read addresses for the three operand ports of the register file. A fourth read port carries the register named by a store or a move from a special register. That request is independent of the vector instruction and can be issued in the same cycle.

The routing modes let one multiply-add datapath serve several operand shapes. The straight mode uses one field per port. Two modes pair SRC1 with its odd partner register. Three modes slice the four-register group that SRC1 points into, and one of these brings in the extra vector register. A port whose request is idle keeps its last address and drops its enable, so the file sees no address toggling on idle ports. Every output is registered.

Top module: `vrp_router`

## Requirements
- R1: While rst_n is low, and on the first sampling after reset, all four enables are 0 and all four addresses are 0.
- R2: Mode 0 (route_mode 3'd0) drives port 0 with SRC1, port 1 with SRC2 and port 2 with SRC3.
- R3: Mode 1 (3'd1) drives port 0 with SRC1, port 1 with SRC2 and port 2 with SRC1 having bit 0 forced to 1.
- R4: Mode 2 (3'd2) drives port 0 with SRC1, port 1 with SRC2 having bit 0 inverted, and port 2 with SRC1 having bit 0 forced to 1.
- R5: Mode 3 (3'd3) drives ports 0, 1 and 2 with quad elements 2, 3 and 0 of SRC1. Quad element k is SRC1 with its low two bits replaced by k.
- R6: Mode 4 (3'd4) drives port 0 with quad element 2 of SRC1, port 1 with SRC2 and port 2 with quad element 3 of SRC1.
- R7: Mode 5 (3'd5) drives port 0 with quad element 1 of SRC1, port 1 with the extra register index vx_sel, and port 2 with quad element 0 of SRC1.
- R8: Port 3 is enabled exactly when st_req was high, and it then carries st_reg. st_req and st_reg never change ports 0 to 2.
- R9: Every output reflects the inputs sampled at the previous rising clock edge. This is one cycle of latency.
- R10: When its request is low (vec_valid for ports 0 to 2, st_req for port 3), a port's enable is 0 and its address keeps its previous value.
- R11: Modes 6 and 7 (3'd6, 3'd7) route the same way as mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_valid | input | 1 | A vector instruction needs operand reads this cycle |
| route_mode | input | 3 | Operand routing mode |
| src1 | input | REG_AW | First source register field |
| src2 | input | REG_AW | Second source register field |
| src3 | input | REG_AW | Third source register field |
| vx_sel | input | REG_AW | Index of the extra vector register |
| st_req | input | 1 | Store or special-register move needs a read |
| st_reg | input | REG_AW | Register for the store/move read |
| rd_addr0 | output | REG_AW | Port 0 read address |
| rd_addr1 | output | REG_AW | Port 1 read address |
| rd_addr2 | output | REG_AW | Port 2 read address |
| rd_addr3 | output | REG_AW | Port 3 (store/move) read address |
| rd_en | output | 4 | Per-port read enables, bit n for port n |

## Verification
The bench builds the router with its default REG_AW of 5, which gives a 32-entry file. At that width the top quad group (registers 28 to 31) and odd SRC1 values are within reach. These are the cases where forcing bit 0 or replacing the low two bits leaves the address unchanged, or moves it down instead of up. Random fields, all eight mode encodings and independent vec_valid and st_req patterns are applied, so the bench sees idle ports holding while the other group is loading. Directed cycles add all-ones and all-zeros fields.

// File: rtl/vrp_pkg.sv
package vrp_pkg;

    // Routing mode encodings presented by decode
    typedef enum logic [2:0] {
        RM_STRAIGHT  = 3'd0,
        RM_PAIR      = 3'd1,
        RM_PAIR_FLIP = 3'd2,
        RM_QUAD_230  = 3'd3,
        RM_QUAD_MIX  = 3'd4,
        RM_QUAD_VX   = 3'd5,
        RM_RSV6      = 3'd6,
        RM_RSV7      = 3'd7
    } route_mode_t;

    localparam int unsigned NUM_VEC_PORTS = 3;
    localparam int unsigned NUM_PORTS     = NUM_VEC_PORTS + 1;

endpackage

// File: rtl/vrp_mode_mux.sv
module vrp_mode_mux
    import vrp_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  route_mode_t       mode,
    input  logic [REG_AW-1:0] src1,
    input  logic [REG_AW-1:0] src2,
    input  logic [REG_AW-1:0] src3,
    input  logic [REG_AW-1:0] vx_sel,
    output logic [REG_AW-1:0] port0,
    output logic [REG_AW-1:0] port1,
    output logic [REG_AW-1:0] port2
);

    localparam int unsigned GRP_W = REG_AW - 2;

    logic [GRP_W-1:0]  grp;
    logic [REG_AW-1:0] q0, q1, q2, q3, odd1, flip2;

    // Quad group members of SRC1 and the derived variants
    assign grp   = src1[REG_AW-1:2];
    assign q0    = {grp, 2'd0};
    assign q1    = {grp, 2'd1};
    assign q2    = {grp, 2'd2};
    assign q3    = {grp, 2'd3};
    assign odd1  = {src1[REG_AW-1:1], 1'b1};
    assign flip2 = {src2[REG_AW-1:1], ~src2[0]};

    always_comb begin
        unique case (mode)
            RM_PAIR: begin
                port0 = src1;  port1 = src2;   port2 = odd1;
            end
            RM_PAIR_FLIP: begin
                port0 = src1;  port1 = flip2;  port2 = odd1;
            end
            RM_QUAD_230: begin
                port0 = q2;    port1 = q3;     port2 = q0;
            end
            RM_QUAD_MIX: begin
                port0 = q2;    port1 = src2;   port2 = q3;
            end
            RM_QUAD_VX: begin
                port0 = q1;    port1 = vx_sel; port2 = q0;
            end
            RM_STRAIGHT, RM_RSV6, RM_RSV7: begin
                port0 = src1;  port1 = src2;   port2 = src3;
            end
            default: begin
                port0 = src1;  port1 = src2;   port2 = src3;
            end
        endcase
    end

endmodule

// File: rtl/vrp_hold_reg.sv
module vrp_hold_reg #(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [REG_AW-1:0] d,
    output logic [REG_AW-1:0] q,
    output logic              en
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q  <= '0;
            en <= 1'b0;
        end else begin
            en <= load;
            if (load) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/vrp_router.sv
module vrp_router
    import vrp_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_valid,
    input  logic [2:0]        route_mode,
    input  logic [REG_AW-1:0] src1,
    input  logic [REG_AW-1:0] src2,
    input  logic [REG_AW-1:0] src3,
    input  logic [REG_AW-1:0] vx_sel,
    input  logic              st_req,
    input  logic [REG_AW-1:0] st_reg,
    output logic [REG_AW-1:0] rd_addr0,
    output logic [REG_AW-1:0] rd_addr1,
    output logic [REG_AW-1:0] rd_addr2,
    output logic [REG_AW-1:0] rd_addr3,
    output logic [NUM_PORTS-1:0] rd_en
);

    logic [REG_AW-1:0] nxt_addr [NUM_PORTS];
    logic [REG_AW-1:0] cur_addr [NUM_PORTS];
    logic [NUM_PORTS-1:0] load_vec;

    vrp_mode_mux #(.REG_AW(REG_AW)) mux_i (
        .mode   (route_mode_t'(route_mode)),
        .src1   (src1),
        .src2   (src2),
        .src3   (src3),
        .vx_sel (vx_sel),
        .port0  (nxt_addr[0]),
        .port1  (nxt_addr[1]),
        .port2  (nxt_addr[2])
    );

    // Store/move port is fed straight from its own request
    assign nxt_addr[NUM_PORTS-1] = st_reg;
    assign load_vec = {st_req, {NUM_VEC_PORTS{vec_valid}}};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        vrp_hold_reg #(.REG_AW(REG_AW)) reg_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_vec[p]),
            .d     (nxt_addr[p]),
            .q     (cur_addr[p]),
            .en    (rd_en[p])
        );
    end

    assign rd_addr0 = cur_addr[0];
    assign rd_addr1 = cur_addr[1];
    assign rd_addr2 = cur_addr[2];
    assign rd_addr3 = cur_addr[3];

endmodule

// File: rtl/vrp_router_chk.sv
module vrp_router_chk #(
    parameter int unsigned REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vec_valid,
    input logic [2:0]        route_mode,
    input logic [REG_AW-1:0] src1,
    input logic [REG_AW-1:0] src2,
    input logic [REG_AW-1:0] src3,
    input logic              st_req,
    input logic [REG_AW-1:0] st_reg,
    input logic [REG_AW-1:0] rd_addr0,
    input logic [REG_AW-1:0] rd_addr1,
    input logic [REG_AW-1:0] rd_addr2,
    input logic [REG_AW-1:0] rd_addr3,
    input logic [3:0]        rd_en
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_en == 4'd0 && rd_addr0 == '0 && rd_addr3 == '0));

    // R2
    straight_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vec_valid) && $past(route_mode) == 3'd0)
        |-> (rd_addr0 == $past(src1) && rd_addr1 == $past(src2) && rd_addr2 == $past(src3)));

    // R5
    quad_230_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vec_valid) && $past(route_mode) == 3'd3)
        |-> (rd_addr0[1:0] == 2'd2 && rd_addr1[1:0] == 2'd3 && rd_addr2[1:0] == 2'd0
             && rd_addr0[REG_AW-1:2] == $past(src1[REG_AW-1:2])));

    // R8
    store_port_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_en[3] == $past(st_req)
                          && (!rd_en[3] || rd_addr3 == $past(st_reg))));

    // R10
    store_port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(st_req)) |-> $stable(rd_addr3));

    // R10
    vec_port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(vec_valid))
        |-> ($stable(rd_addr0) && $stable(rd_addr1) && $stable(rd_addr2) && rd_en[2:0] == 3'd0));

endmodule

bind vrp_router vrp_router_chk #(.REG_AW(REG_AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_valid  (vec_valid),
    .route_mode (route_mode),
    .src1       (src1),
    .src2       (src2),
    .src3       (src3),
    .st_req     (st_req),
    .st_reg     (st_reg),
    .rd_addr0   (rd_addr0),
    .rd_addr1   (rd_addr1),
    .rd_addr2   (rd_addr2),
    .rd_addr3   (rd_addr3),
    .rd_en      (rd_en)
);

// File: tb/vrp_router_tb_top.sv
module vrp_router_tb_top;

    localparam int AW   = 5;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vec_valid = 1'b0;
    logic [2:0]    route_mode = 3'd0;
    logic [AW-1:0] src1 = '0, src2 = '0, src3 = '0, vx_sel = '0, st_reg = '0;
    logic          st_req = 1'b0;
    logic [AW-1:0] rd_addr0, rd_addr1, rd_addr2, rd_addr3;
    logic [3:0]    rd_en;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reference model state: expected outputs after the next edge
    int exp_a [4];
    int exp_en [4];

    always #10 clk = ~clk;

    vrp_router #(.REG_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .route_mode(route_mode),
        .src1(src1), .src2(src2), .src3(src3), .vx_sel(vx_sel),
        .st_req(st_req), .st_reg(st_reg),
        .rd_addr0(rd_addr0), .rd_addr1(rd_addr1), .rd_addr2(rd_addr2),
        .rd_addr3(rd_addr3), .rd_en(rd_en)
    );

    function automatic string mode_tag(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic cmp(string tag, int port, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s port %0d: actual %0d expected %0d", tag, port, act, exp);
        end
    endtask

    // R9: model advances once per edge from the inputs held across it
    task automatic model_step(int m);
        int s1 = int'(src1), s2 = int'(src2), s3 = int'(src3);
        int grp = s1 & ~3;
        int r [3];
        case (m)
            1: begin r[0] = s1; r[1] = s2;          r[2] = s1 | 1; end
            2: begin r[0] = s1; r[1] = s2 ^ 1;      r[2] = s1 | 1; end
            3: begin r[0] = grp + 2; r[1] = grp + 3; r[2] = grp; end
            4: begin r[0] = grp + 2; r[1] = s2;     r[2] = grp + 3; end
            5: begin r[0] = grp + 1; r[1] = int'(vx_sel); r[2] = grp; end
            default: begin r[0] = s1; r[1] = s2; r[2] = s3; end
        endcase
        for (int p = 0; p < 3; p++) begin
            exp_en[p] = vec_valid ? 1 : 0;
            if (vec_valid) exp_a[p] = r[p] & MASK;
        end
        exp_en[3] = st_req ? 1 : 0;
        if (st_req) exp_a[3] = int'(st_reg);
    endtask

    task automatic compare_all(int m, bit vv, bit sr);
        string vt = vv ? mode_tag(m) : "R10";
        string st = sr ? "R8" : "R10";
        cmp(vt, 0, int'(rd_addr0), exp_a[0]);
        cmp(vt, 1, int'(rd_addr1), exp_a[1]);
        cmp(vt, 2, int'(rd_addr2), exp_a[2]);
        cmp(vt, 4, int'(rd_en[2:0]), exp_en[0] * 7);
        cmp(st, 3, int'(rd_addr3), exp_a[3]);
        cmp("R8", 5, int'(rd_en[3]), exp_en[3]);
    endtask

    // One cycle: apply inputs on a falling edge, then compare on the next
    task automatic cycle(bit vv, int m, int s1, int s2, int s3, int vx, bit sr, int sreg);
        vec_valid  = vv;
        route_mode = 3'(m);
        src1 = AW'(s1); src2 = AW'(s2); src3 = AW'(s3);
        vx_sel = AW'(vx); st_req = sr; st_reg = AW'(sreg);
        model_step(m);
        @(negedge clk);
        compare_all(m, vv, sr);
    endtask

    initial begin
        for (int p = 0; p < 4; p++) begin exp_a[p] = 0; exp_en[p] = 0; end
        // R1: hold reset with busy inputs
        vec_valid = 1'b1; st_req = 1'b1; src1 = '1; st_reg = '1;
        repeat (3) @(negedge clk);
        cmp("R1", 0, int'(rd_addr0), 0);
        cmp("R1", 3, int'(rd_addr3), 0);
        cmp("R1", 5, int'(rd_en), 0);
        rst_n = 1'b1;
        vec_valid = 1'b0; st_req = 1'b0;
        @(negedge clk);
        cmp("R1", 5, int'(rd_en), 0);
        cmp("R1", 1, int'(rd_addr1), 0);

        // Directed corners: top quad group, all modes, odd SRC1
        for (int m = 0; m < 8; m++) begin
            cycle(1'b1, m, MASK, MASK, MASK, MASK, 1'b0, 0);
            cycle(1'b1, m, 0, 0, 0, 0, 1'b1, MASK);
            cycle(1'b1, m, 29, 6, 17, 3, 1'b0, 0);
        end
        // R10: idle vector ports hold while store port loads, and vice versa
        cycle(1'b1, 3, 13, 2, 9, 5, 1'b0, 0);
        cycle(1'b0, 0, 1, 1, 1, 1, 1'b1, 22);
        cycle(1'b0, 5, 30, 30, 30, 30, 1'b0, 7);
        // R8: store traffic across every mode does not disturb ports 0-2
        for (int m = 0; m < 8; m++) cycle(1'b1, m, 21, 10, 4, 8, 1'b1, m * 3);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom % 4) != 0, int'($urandom % 8),
                  int'($urandom & MASK), int'($urandom & MASK), int'($urandom & MASK),
                  int'($urandom & MASK), ($urandom % 3) == 0, int'($urandom & MASK));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule